// File: doc/BRIEF.md
# Constant-Time Montgomery Modular Multiplier

This block forms the Montgomery product of two 64-bit residues for an odd 64-bit modulus. With R = 2^64 it returns x·y·R⁻¹ mod m, fully reduced into [0, m). The caller supplies both operands, the modulus and the negated inverse of the modulus modulo 2^64, then raises `start` for one cycle. Exactly three clock edges after that the result appears with a one-cycle `done` pulse.

The datapath is a four-register pipeline: a full 128-bit product, a low-half product that gives the folding quotient, a folding add whose low-half carry is always added in, and a final stage that always subtracts the modulus and picks the answer with a multiplexer. Every operation takes the same path through the same logic. The cycle count and the order of operations therefore do not depend on operand values, on whether the low half carries, or on whether a subtraction is needed.

A new operation may start on every cycle. Moving a value into the Montgomery domain uses R² mod m as the second operand. Moving it back out uses the constant 1.

Top module: `mont_mul_ct`

## Requirements
- R1: For odd `modulus` and `a_res`, `b_res` < `modulus`, `result` equals a·b·2^-64 mod m when `done` is high.
- R2: Whenever `done` is high, `result` is strictly less than the modulus of the operation it belongs to.
- R3: If `start` is high at a rising edge, `done` is high for exactly the cycle after the third following rising edge. Each accepted start produces exactly one such pulse.
- R4: The start-to-done latency is the same whether or not the final subtraction of the modulus takes place.
- R5: `start` may be high on consecutive cycles. Results then appear on consecutive cycles in the order the operations were issued.
- R6: While `rst_n` is low at a rising edge, the next cycle shows `done` = 0 and `result` = 0. Operations in flight at reset never produce a `done`.
- R7: Between `done` pulses, `result` keeps its last value. Operand changes without `start` have no effect on it.
- R8: A second operand of 2^128 mod m yields a·2^64 mod m. Feeding that value back with a second operand of 1 returns the original a.
- R9: Moduli of 2^63 and above are handled correctly, including cases where the folded sum exceeds 64 bits before reduction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launches one operation with the operands present in this cycle |
| a_res | input | 64 | First operand, already a residue below the modulus |
| b_res | input | 64 | Second operand, already a residue below the modulus |
| modulus | input | 64 | Odd modulus m |
| neg_inv | input | 64 | −m⁻¹ mod 2^64, computed by the caller |
| done | output | 1 | One-cycle pulse per completed operation |
| result | output | 64 | Montgomery product, held until the next completion |

## Verification
The assertions take for granted that every operation is launched with an odd modulus, both operands below it, and a matching negated inverse. The range and identity properties make no claim outside those conditions. The bench therefore draws operands by reducing random words modulo a random modulus forced odd, and it derives each negated inverse by Newton iteration. Its corner operands (m−1, m−2, 0, 1) are chosen against moduli near 2^64, near 2^63, and small moduli such as 3 and 7, so that both the subtract and no-subtract outcomes occur.

// File: rtl/mont_pkg.sv
// Shared constants for the Montgomery multiplier.
// Assumes a word width that is a whole multiple of the limb width.
package mont_pkg;
    localparam int WORD_W      = 64;  // residue and modulus width
    localparam int LIMB_W      = 16;  // partial-product slice width
    localparam int PIPE_STAGES = 4;   // register stages from start to result
endpackage

// File: rtl/mont_limb_mul.sv
// Limb-sliced multiplier. Splits both operands into LIMB-wide slices,
// forms every slice product, and sums them at their weights.
// With LOW_HALF set, it drops every product that lands wholly above bit W-1
// and returns only the low W bits (the product modulo 2^W).
// Assumes W is a multiple of LIMB. Purely combinational.
module mont_limb_mul #(
    parameter int W        = 64,
    parameter int LIMB     = 16,
    parameter bit LOW_HALF = 1'b0,
    localparam int NL      = W / LIMB,
    localparam int OW      = LOW_HALF ? W : 2 * W
) (
    input  logic [W-1:0]  x,
    input  logic [W-1:0]  y,
    output logic [OW-1:0] p
);
    localparam int AW = 2 * W;

    logic [2*LIMB-1:0] pp [NL][NL];
    logic [OW-1:0]     acc;

    // one slice product per limb pair; the truncated variant skips high ones
    for (genvar i = 0; i < NL; i++) begin : g_row
        for (genvar j = 0; j < NL; j++) begin : g_col
            if (!LOW_HALF || (i + j) < NL) begin : g_used
                assign pp[i][j] = ({{LIMB{1'b0}}, x[i*LIMB +: LIMB]}) *
                                  ({{LIMB{1'b0}}, y[j*LIMB +: LIMB]});
            end else begin : g_skip
                assign pp[i][j] = '0;
            end
        end
    end

    // weighted sum of all slice products, truncated to the output width
    always_comb begin
        acc = '0;
        for (int i = 0; i < NL; i++) begin
            for (int j = 0; j < NL; j++) begin
                acc = acc + OW'(AW'(pp[i][j]) << (LIMB * (i + j)));
            end
        end
    end

    assign p = acc;
endmodule

// File: rtl/mont_redc_fold.sv
// Folding step of the reduction: adds q*m to t and keeps the upper half.
// The low halves are summed and the carry is always derived and added into
// the high half, whether or not it is set. The sum is W+1 bits wide.
// Assumes q was chosen so the low half of t + q*m is zero. Combinational.
module mont_redc_fold #(
    parameter int W = 64
) (
    input  logic [2*W-1:0] t,
    input  logic [2*W-1:0] qm,
    output logic [W:0]     u
);
    logic [W-1:0] lo_sum;
    logic         lo_carry;

    // low-half addition; a wrap-around is detected by comparison
    always_comb begin
        lo_sum   = t[W-1:0] + qm[W-1:0];
        lo_carry = (lo_sum < t[W-1:0]);
    end

    // high-half addition with the carry always folded in
    always_comb begin
        u = {1'b0, t[2*W-1:W]} + {1'b0, qm[2*W-1:W]} + {{W{1'b0}}, lo_carry};
    end
endmodule

// File: rtl/mont_cond_sub.sv
// Final reduction. The difference u - m is computed on every call, and a
// multiplexer picks it when u overflowed W bits or did not borrow.
// Assumes u < 2m. Combinational, with a single select and no early exit.
module mont_cond_sub #(
    parameter int W = 64
) (
    input  logic [W:0]   u,
    input  logic [W-1:0] m,
    output logic [W-1:0] y
);
    logic [W:0] diff;
    logic       take_diff;

    // unconditional subtraction of the low word
    always_comb diff = {1'b0, u[W-1:0]} - {1'b0, m};

    // select: an overflow bit or the absence of a borrow means u >= m
    always_comb begin
        take_diff = u[W] | ~diff[W];
        y         = take_diff ? diff[W-1:0] : u[W-1:0];
    end
endmodule

// File: rtl/mont_mul_ct.sv
// Pipelined Montgomery multiplier with a fixed latency.
// Stage 1 registers a*b, stage 2 registers q = (t mod 2^W)*neg_inv mod 2^W,
// stage 3 registers the folded sum (t + q*m) / 2^W, and stage 4 registers
// the fully reduced result. The result appears three edges after the start edge.
// Assumes an odd modulus, operands below it, and neg_inv = -m^-1 mod 2^W.
// Uses a synchronous active-low reset. A new operation is accepted every cycle.
module mont_mul_ct
    import mont_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int LIMB = LIMB_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] a_res,
    input  logic [W-1:0] b_res,
    input  logic [W-1:0] modulus,
    input  logic [W-1:0] neg_inv,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int DW = 2 * W;

    // stage registers
    logic           v1, v2, v3;
    logic [DW-1:0]  t1, t2;
    logic [W-1:0]   m1, m2, m3;
    logic [W-1:0]   ni1;
    logic [W-1:0]   q2;
    logic [W:0]     u3;

    // combinational stage outputs
    logic [DW-1:0]  prod_ab;
    logic [W-1:0]   q_next;
    logic [DW-1:0]  prod_qm;
    logic [W:0]     u_next;
    logic [W-1:0]   r_next;

    mont_limb_mul #(.W(W), .LIMB(LIMB), .LOW_HALF(1'b0)) u_mul_ab (
        .x (a_res),
        .y (b_res),
        .p (prod_ab)
    );

    mont_limb_mul #(.W(W), .LIMB(LIMB), .LOW_HALF(1'b1)) u_mul_q (
        .x (t1[W-1:0]),
        .y (ni1),
        .p (q_next)
    );

    mont_limb_mul #(.W(W), .LIMB(LIMB), .LOW_HALF(1'b0)) u_mul_qm (
        .x (q2),
        .y (m2),
        .p (prod_qm)
    );

    mont_redc_fold #(.W(W)) u_fold (
        .t  (t2),
        .qm (prod_qm),
        .u  (u_next)
    );

    mont_cond_sub #(.W(W)) u_sub (
        .u (u3),
        .m (m3),
        .y (r_next)
    );

    // stage 1: capture the full operand product with its modulus constants
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1  <= 1'b0;
            t1  <= '0;
            m1  <= '0;
            ni1 <= '0;
        end else begin
            v1 <= start;
            if (start) begin
                t1  <= prod_ab;
                m1  <= modulus;
                ni1 <= neg_inv;
            end
        end
    end

    // stage 2: capture the folding quotient next to the product
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2 <= 1'b0;
            t2 <= '0;
            m2 <= '0;
            q2 <= '0;
        end else begin
            v2 <= v1;
            if (v1) begin
                t2 <= t1;
                m2 <= m1;
                q2 <= q_next;
            end
        end
    end

    // stage 3: capture the folded, shifted sum including its overflow bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v3 <= 1'b0;
            u3 <= '0;
            m3 <= '0;
        end else begin
            v3 <= v2;
            if (v2) begin
                u3 <= u_next;
                m3 <= m2;
            end
        end
    end

    // stage 4: publish the reduced result with its completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= v3;
            if (v3) begin
                result <= r_next;
            end
        end
    end
endmodule

// File: rtl/mont_mul_ct_chk.sv
// Property checker for mont_mul_ct, attached by bind.
// It keeps its own history of starts and operands so that each completion
// can be checked against the operation that launched it.
// Assumes every start carries an odd modulus with both operands below it.
module mont_mul_ct_chk #(
    parameter int W   = 64,
    parameter int LAT = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] a_res,
    input logic [W-1:0] b_res,
    input logic [W-1:0] modulus,
    input logic         done,
    input logic [W-1:0] result
);
    logic [LAT-1:0] launch_q;
    logic [W-1:0]   a_h [LAT];
    logic [W-1:0]   b_h [LAT];
    logic [W-1:0]   m_h [LAT];
    logic           rst_q;
    logic [2*W-1:0] lhs, rhs;

    // record reset history and starts in flight
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        if (!rst_n) launch_q <= '0;
        else        launch_q <= {launch_q[LAT-2:0], start};
    end

    // operand history, aligned with launch_q
    always_ff @(posedge clk) begin
        a_h[0] <= a_res;
        b_h[0] <= b_res;
        m_h[0] <= modulus;
        for (int k = 1; k < LAT; k++) begin
            a_h[k] <= a_h[k-1];
            b_h[k] <= b_h[k-1];
            m_h[k] <= m_h[k-1];
        end
    end

    // both sides of result * 2^W == a * b (mod m)
    always_comb begin
        lhs = {result, {W{1'b0}}} % {{W{1'b0}}, m_h[LAT-1]};
        rhs = ({{W{1'b0}}, a_h[LAT-1]} * {{W{1'b0}}, b_h[LAT-1]}) % {{W{1'b0}}, m_h[LAT-1]};
    end

    // R3
    done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        done == launch_q[LAT-1]);

    // R1
    mont_identity_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        done |-> (lhs == rhs));

    // R2
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        done |-> (result < m_h[LAT-1]));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !rst_q)
        !done |-> $stable(result));

    // R6
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && result == '0));
endmodule

bind mont_mul_ct mont_mul_ct_chk #(.W(W), .LAT(mont_pkg::PIPE_STAGES)) u_mont_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a_res   (a_res),
    .b_res   (b_res),
    .modulus (modulus),
    .done    (done),
    .result  (result)
);

// File: tb/test_mont_mul_ct.sv
// Directed bench for mont_mul_ct: one task per scenario.
module test_mont_mul_ct;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [63:0] a_i = '0, b_i = '0, m_i = 64'd1, ni_i = '0;
    logic        done;
    logic [63:0] result;

    int nchk = 0;
    int nerr = 0;
    int n_sub = 0, n_nosub = 0, n_ovf = 0;
    int lat_sub = -1, lat_nosub = -1;

    localparam int EXP_LAT = 3;  // edges after the start edge

    always #4 clk = ~clk;  // 125 MHz

    mont_mul_ct i_mont_mul_ct (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .a_res   (a_i),
        .b_res   (b_i),
        .modulus (m_i),
        .neg_inv (ni_i),
        .done    (done),
        .result  (result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // -m^-1 mod 2^64 by Newton iteration
    function automatic logic [63:0] neg_inverse(input logic [63:0] m);
        logic [63:0] inv = m;
        for (int k = 0; k < 6; k++) inv = inv * (64'd2 - m * inv);
        return -inv;
    endfunction

    // a*b*2^-64 mod m by 64 modular halvings
    function automatic logic [63:0] ref_mont(input logic [63:0] a, b, m);
        logic [127:0] p = {64'd0, a} * {64'd0, b};
        logic [64:0]  v = 65'(p % {64'd0, m});
        for (int k = 0; k < 64; k++) v = v[0] ? (v + {1'b0, m}) >> 1 : v >> 1;
        return v[63:0];
    endfunction

    // classify: does the folded value reach m, and does it exceed 64 bits
    function automatic logic [1:0] classify(input logic [63:0] a, b, m);
        logic [127:0] t = {64'd0, a} * {64'd0, b};
        logic [63:0]  q = t[63:0] * neg_inverse(m);
        logic [128:0] s = {1'b0, t} + ({65'd0, q} * {65'd0, m});
        logic [64:0]  u = s[128:64];
        return {u[64], (u >= {1'b0, m})};
    endfunction

    // launch one operation and wait for its completion
    task automatic run_op(input logic [63:0] a, b, m,
                          output logic [63:0] res, output int lat);
        @(negedge clk);
        a_i = a; b_i = b; m_i = m; ni_i = neg_inverse(m); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 20) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        res = result;
    endtask

    // one operation checked for value, range, latency and pulse width
    task automatic check_op(input logic [63:0] a, b, m, input string req);
        logic [63:0] res;
        int          lat;
        logic [1:0]  cls = classify(a, b, m);
        logic [63:0] exp = ref_mont(a, b, m);
        run_op(a, b, m, res, lat);
        chk(res == exp, req, "product value", res, exp);
        chk(res < m, "R2", "result below modulus", res, m);
        chk(lat == EXP_LAT, "R3", "start to done edges", lat, EXP_LAT);
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R3", "done lasts one cycle", done, 0);
        if (cls[0]) begin n_sub++; lat_sub = lat; end
        else begin n_nosub++; lat_nosub = lat; end
        if (cls[1]) n_ovf++;
    endtask

    task automatic t_reset_state;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done, "R6", "done in reset", done, 0);
        chk(result == 0, "R6", "result in reset", result, 0);
        rst_n = 1'b1;
        // launch, then reset before completion
        @(negedge clk);
        a_i = 64'd5; b_i = 64'd6; m_i = 64'd11; ni_i = neg_inverse(64'd11); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 8; k++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(!seen, "R6", "no done for flushed op", seen, 0);
        end
        chk(result == 0, "R6", "result still cleared", result, 0);
    endtask

    task automatic t_random_ops;
        for (int k = 0; k < 40; k++) begin
            logic [63:0] m = {$urandom, $urandom} | 64'd1;
            logic [63:0] a = {$urandom, $urandom} % m;
            logic [63:0] b = {$urandom, $urandom} % m;
            check_op(a, b, m, "R1");
        end
    endtask

    task automatic t_wide_modulus;
        logic [63:0] mods [5] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFC5,
                                  64'h8000_0000_0000_0001, 64'hC000_0000_0000_0003,
                                  64'hFFFF_FFFF_0000_0001};
        for (int k = 0; k < 5; k++) begin
            check_op(mods[k] - 1, mods[k] - 1, mods[k], "R9");
            check_op(mods[k] - 2, mods[k] - 1, mods[k], "R9");
            check_op(mods[k] - 1, 64'd1, mods[k], "R9");
            check_op(64'd0, mods[k] - 1, mods[k], "R9");
            for (int j = 0; j < 4; j++)
                check_op({$urandom, $urandom} % mods[k], {$urandom, $urandom} % mods[k],
                         mods[k], "R9");
        end
        chk(n_ovf > 0, "R9", "overflow cases exercised", n_ovf, 1);
    endtask

    task automatic t_small_modulus;
        for (int a = 0; a < 7; a++)
            for (int b = 0; b < 7; b++)
                check_op(64'(a), 64'(b), 64'd7, "R1");
        check_op(64'd2, 64'd2, 64'd3, "R1");
    endtask

    task automatic t_latency_classes;
        chk(n_sub > 0, "R4", "subtracting cases seen", n_sub, 1);
        chk(n_nosub > 0, "R4", "non-subtracting cases seen", n_nosub, 1);
        chk(lat_sub == lat_nosub, "R4", "equal latency both classes", lat_sub, lat_nosub);
    endtask

    task automatic t_domain_conv;
        logic [63:0] m = 64'hF123_4567_89AB_CDEF;
        logic [63:0] a = 64'h0123_4567_DEAD_BEEF;
        logic [128:0] big = 129'd1 << 128;
        logic [63:0] r2 = 64'(big % {65'd0, m});
        logic [63:0] in_dom, back;
        logic [63:0] exp_in = 64'({a, 64'd0} % {64'd0, m});
        int lat;
        run_op(a, r2, m, in_dom, lat);
        chk(in_dom == exp_in, "R8", "into domain", in_dom, exp_in);
        run_op(in_dom, 64'd1, m, back, lat);
        chk(back == a, "R8", "out of domain round trip", back, a);
    endtask

    task automatic t_back_to_back;
        logic [63:0] av [5], bv [5], mv [5], ev [5];
        for (int k = 0; k < 5; k++) begin
            mv[k] = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
            av[k] = {$urandom, $urandom} % mv[k];
            bv[k] = {$urandom, $urandom} % mv[k];
            ev[k] = ref_mont(av[k], bv[k], mv[k]);
        end
        fork
            begin
                for (int k = 0; k < 5; k++) begin
                    @(negedge clk);
                    a_i = av[k]; b_i = bv[k]; m_i = mv[k]; ni_i = neg_inverse(mv[k]);
                    start = 1'b1;
                end
                @(negedge clk);
                start = 1'b0;
            end
            begin
                int guard = 0;
                @(negedge clk);
                while (!done && guard < 20) begin @(negedge clk); guard++; end
                for (int k = 0; k < 5; k++) begin
                    chk(done, "R5", "consecutive done", done, 1);
                    chk(result == ev[k], "R5", "in-order result", result, ev[k]);
                    @(negedge clk);
                end
                chk(!done, "R5", "done drops after burst", done, 0);
            end
        join
    endtask

    task automatic t_hold;
        logic [63:0] res, held;
        int lat;
        run_op(64'd123456789, 64'd987654321, 64'hFFFF_FFFF_FFFF_FFC5, res, lat);
        held = res;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
            m_i = {$urandom, $urandom} | 64'd1;
        end
        chk(!done, "R7", "no done without start", done, 0);
        chk(result == held, "R7", "result held", result, held);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset_state();
        t_random_ops();
        t_wide_modulus();
        t_small_modulus();
        t_latency_classes();
        t_domain_conv();
        t_back_to_back();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule